// File: doc/BRIEF.md
# Chip-Select Framed Serial Frame Loader

This block takes frames from a host over three wires: an active-low chip select, a data line and a serial clock. All three are brought into the system clock domain through two-flop synchronizers. Each rising serial clock edge seen while chip select is low shifts one bit into a 112-position shift register. The host sends the first bit first, and the last bit of a frame is a mode bit. The system clock must run at least eight times faster than the serial clock.

When chip select returns high, the block reads the mode bit and copies the shift register into one of two holding latches. A mode bit of 1 means a 112-bit display frame, which fills a 111-bit segment pattern latch. A mode bit of 0 means a 16-bit dimming frame, which fills a 10-bit brightness latch. A frame with fewer than 16 bits is discarded. Each latch update raises a one-cycle pulse so that downstream drive logic can pick up the new value.

Top module: `csf_serial_loader`

## Requirements
- R1: While reset is asserted and after it is released, `seg_pattern` and `dim_level` are all zero and neither update pulse is high.
- R2: Each rising edge of `ser_clk` while `ser_cs_n` is low shifts `ser_data` in, and older bits move one position lower. After exactly 112 bits, frame bit k (k = 1 is the first bit sent) sits at position k.
- R3: `ser_clk` edges while `ser_cs_n` is high change nothing. The bits received in later low periods line up as if those edges never happened.
- R4: The latch update happens only after a rising edge of `ser_cs_n`. The latch is chosen by the bit at position 112, which is the most recently received bit.
- R5: When the mode bit is 1, `seg_pattern[k-1]` takes position k for k = 1..111. `dim_level` keeps its value, and `display_update` is high for one cycle.
- R6: When the mode bit is 0, `dim_level[j-1]` takes position 96+j for j = 1..10, so the LSB is the first bit of a 16-bit frame. Positions 107..111 have no effect, `seg_pattern` keeps its value, and `dim_update` is high for one cycle.
- R7: If chip select rises after fewer than 16 bits since it fell, no pulse is produced and both latches keep their values. The received bits stay in the shift register.
- R8: `display_update` and `dim_update` are never high together, and neither is high for two cycles in a row.
- R9: If more than 112 bits are sent in one frame, only the last 112 received take effect. The bit counter saturates at 112.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Active-low chip select from the host |
| ser_clk | input | 1 | Serial clock from the host |
| ser_data | input | 1 | Serial data, sampled on the rising serial clock edge |
| seg_pattern | output | 111 | Display segment pattern latch |
| dim_level | output | 10 | Brightness code latch |
| display_update | output | 1 | One-cycle pulse when `seg_pattern` is loaded |
| dim_update | output | 1 | One-cycle pulse when `dim_level` is loaded |

## Verification
The assertions check four things on every cycle. The shift register holds still whenever the synchronized chip select is high. Each latch changes only together with its own pulse. The pulses are exclusive and last one cycle. The bit counter never passes its ceiling, and a short frame never produces a pulse. Bit ordering cannot be shown by the assertions: where the first bit ends up, which positions feed the brightness code, and whether ignored clocks keep a split frame aligned. The bench's scenarios show these, comparing each update against an expected value that the driver queues for it.

// File: rtl/csf_pkg.sv
package csf_pkg;
  localparam int unsigned CSF_FRAME_BITS = 112;
  localparam int unsigned CSF_DISP_BITS  = 111;
  localparam int unsigned CSF_DIM_BITS   = 10;
  localparam int unsigned CSF_DIM_BASE   = 96;
  localparam int unsigned CSF_MIN_BITS   = 16;

  typedef enum logic [1:0] {
    CSF_UPD_NONE = 2'd0,
    CSF_UPD_DISP = 2'd1,
    CSF_UPD_DIM  = 2'd2
  } csf_upd_e;
endpackage

// File: rtl/csf_sync.sv
module csf_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= RST_VAL;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/csf_frontend.sv
module csf_frontend #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_cs_n,
  input  logic ser_clk,
  input  logic ser_data,
  output logic shift_en,
  output logic shift_bit,
  output logic frame_start,
  output logic frame_end,
  output logic cs_idle
);
  logic [2:0] raw_vec;
  logic [2:0] sync_vec;
  logic       s_clk, s_cs_n, s_data;
  logic       clk_prev_q, clk_prev_d;
  logic       cs_prev_q, cs_prev_d;

  assign raw_vec = {ser_clk, ser_cs_n, ser_data};

  csf_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_vec),
    .q    (sync_vec)
  );

  assign s_clk  = sync_vec[2];
  assign s_cs_n = sync_vec[1];
  assign s_data = sync_vec[0];

  always_comb begin
    clk_prev_d  = s_clk;
    cs_prev_d   = s_cs_n;
    shift_en    = s_clk & ~clk_prev_q & ~s_cs_n;
    shift_bit   = s_data;
    frame_start = ~s_cs_n & cs_prev_q;
    frame_end   = s_cs_n & ~cs_prev_q;
    cs_idle     = s_cs_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      cs_prev_q  <= 1'b1;
    end else begin
      clk_prev_q <= clk_prev_d;
      cs_prev_q  <= cs_prev_d;
    end
  end

  // R3: a shift is never requested while chip select is seen high
  p_no_shift_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |-> !shift_en);
endmodule

// File: rtl/csf_shifter.sv
module csf_shifter #(
  parameter int unsigned FRAME_BITS = 112,
  localparam int unsigned CW = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift_en,
  input  logic                  shift_bit,
  input  logic                  frame_start,
  input  logic                  cs_idle,
  output logic [FRAME_BITS-1:0] sreg,
  output logic [CW-1:0]         bit_cnt
);
  logic [FRAME_BITS-1:0] sreg_q, sreg_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic                  sreg_en, cnt_en;
  logic                  cnt_full;

  assign cnt_full = (cnt_q == CW'(FRAME_BITS));

  always_comb begin
    sreg_en = shift_en;
    sreg_d  = {shift_bit, sreg_q[FRAME_BITS-1:1]};
    cnt_en  = frame_start | (shift_en & ~cnt_full);
    if (frame_start) cnt_d = shift_en ? CW'(1) : '0;
    else             cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sreg_q <= '0;
    else if (sreg_en) sreg_q <= sreg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign sreg    = sreg_q;
  assign bit_cnt = cnt_q;

  // R3: register frozen while chip select is idle
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> $stable(sreg_q));
  // R9: counter ceiling
  p_cnt_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(FRAME_BITS));
  // R2: a shift moves the previous top bit one place down
  p_shift_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sreg_q[FRAME_BITS-2] == $past(sreg_q[FRAME_BITS-1])));
endmodule

// File: rtl/csf_commit.sv
module csf_commit
  import csf_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 112,
  parameter int unsigned DISP_BITS  = 111,
  parameter int unsigned DIM_BITS   = 10,
  parameter int unsigned DIM_BASE   = 96,
  parameter int unsigned MIN_BITS   = 16,
  localparam int unsigned CW = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_end,
  input  logic [FRAME_BITS-1:0] sreg,
  input  logic [CW-1:0]         bit_cnt,
  output logic [DISP_BITS-1:0]  disp_out,
  output logic [DIM_BITS-1:0]   dim_out,
  output logic                  disp_pulse,
  output logic                  dim_pulse
);
  csf_upd_e             kind;
  logic                 long_enough;
  logic                 mode_bit;
  logic [DISP_BITS-1:0] disp_q, disp_d;
  logic [DIM_BITS-1:0]  dim_q, dim_d;
  logic                 disp_en, dim_en;
  logic                 disp_pulse_q, dim_pulse_q;

  always_comb begin
    long_enough = (bit_cnt >= CW'(MIN_BITS));
    mode_bit    = sreg[FRAME_BITS-1];
    kind        = CSF_UPD_NONE;
    if (frame_end && long_enough) kind = mode_bit ? CSF_UPD_DISP : CSF_UPD_DIM;
    disp_en = (kind == CSF_UPD_DISP);
    dim_en  = (kind == CSF_UPD_DIM);
    disp_d  = sreg[DISP_BITS-1:0];
    dim_d   = sreg[DIM_BASE +: DIM_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       disp_q <= '0;
    else if (disp_en) disp_q <= disp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dim_q <= '0;
    else if (dim_en) dim_q <= dim_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_pulse_q <= 1'b0;
      dim_pulse_q  <= 1'b0;
    end else begin
      disp_pulse_q <= disp_en;
      dim_pulse_q  <= dim_en;
    end
  end

  assign disp_out   = disp_q;
  assign dim_out    = dim_q;
  assign disp_pulse = disp_pulse_q;
  assign dim_pulse  = dim_pulse_q;

  // R5: segment latch moves only with its pulse
  p_disp_only_on_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_pulse_q |-> $stable(disp_q));
  // R6: brightness latch moves only with its pulse
  p_dim_only_on_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dim_pulse_q |-> $stable(dim_q));
  // R7: a short frame is dropped
  p_short_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && (bit_cnt < CW'(MIN_BITS))) |=> (!disp_pulse_q && !dim_pulse_q));
  // R8: pulses exclusive and single-cycle
  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({disp_pulse_q, dim_pulse_q}));
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_pulse_q || dim_pulse_q) |=> (!disp_pulse_q && !dim_pulse_q));
  // R4: an update only follows a chip select release
  p_update_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> (!disp_pulse_q && !dim_pulse_q));
endmodule

// File: rtl/csf_serial_loader.sv
module csf_serial_loader
  import csf_pkg::*;
#(
  parameter int unsigned FRAME_BITS  = CSF_FRAME_BITS,
  parameter int unsigned DISP_BITS   = CSF_DISP_BITS,
  parameter int unsigned DIM_BITS    = CSF_DIM_BITS,
  parameter int unsigned DIM_BASE    = CSF_DIM_BASE,
  parameter int unsigned MIN_BITS    = CSF_MIN_BITS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_cs_n,
  input  logic                 ser_clk,
  input  logic                 ser_data,
  output logic [DISP_BITS-1:0] seg_pattern,
  output logic [DIM_BITS-1:0]  dim_level,
  output logic                 display_update,
  output logic                 dim_update
);
  localparam int unsigned CW = $clog2(FRAME_BITS + 1);

  logic                  shift_en, shift_bit;
  logic                  frame_start, frame_end, cs_idle;
  logic [FRAME_BITS-1:0] sreg;
  logic [CW-1:0]         bit_cnt;

  csf_frontend #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_frontend (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_cs_n   (ser_cs_n),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .shift_en   (shift_en),
    .shift_bit  (shift_bit),
    .frame_start(frame_start),
    .frame_end  (frame_end),
    .cs_idle    (cs_idle)
  );

  csf_shifter #(
    .FRAME_BITS(FRAME_BITS)
  ) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .shift_bit  (shift_bit),
    .frame_start(frame_start),
    .cs_idle    (cs_idle),
    .sreg       (sreg),
    .bit_cnt    (bit_cnt)
  );

  csf_commit #(
    .FRAME_BITS(FRAME_BITS),
    .DISP_BITS (DISP_BITS),
    .DIM_BITS  (DIM_BITS),
    .DIM_BASE  (DIM_BASE),
    .MIN_BITS  (MIN_BITS)
  ) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .sreg      (sreg),
    .bit_cnt   (bit_cnt),
    .disp_out  (seg_pattern),
    .dim_out   (dim_level),
    .disp_pulse(display_update),
    .dim_pulse (dim_update)
  );

  // R1: outputs quiet right after reset release
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!display_update && !dim_update));
endmodule

// File: tb/csf_serial_loader_bench.sv
module csf_serial_loader_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         ser_cs_n, ser_clk, ser_data;
  logic [110:0] seg_pattern;
  logic [9:0]   dim_level;
  logic         display_update, dim_update;

  typedef struct {
    bit           is_disp;
    logic [110:0] disp;
    logic [9:0]   dim;
    string        req;
  } exp_t;

  exp_t         sb_q[$];
  int           n_checks = 0;
  int           n_fail   = 0;
  logic [110:0] model_disp;
  logic [9:0]   model_dim;
  bit           prev_pulse;

  always #5ns clk = ~clk;

  csf_serial_loader u_csf_serial_loader (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_cs_n      (ser_cs_n),
    .ser_clk       (ser_clk),
    .ser_data      (ser_data),
    .seg_pattern   (seg_pattern),
    .dim_level     (dim_level),
    .display_update(display_update),
    .dim_update    (dim_update)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [127:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      ser_data = v[i];
      #50ns ser_clk = 1'b1;
      #100ns ser_clk = 1'b0;
      #50ns;
    end
  endtask

  task automatic open_cs();
    ser_cs_n = 1'b0;
    #100ns;
  endtask

  task automatic close_cs();
    #100ns ser_cs_n = 1'b1;
    #400ns;
  endtask

  task automatic push_disp(input logic [110:0] d, input string req);
    exp_t e;
    model_disp = d;
    e.is_disp = 1'b1; e.disp = model_disp; e.dim = model_dim; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic push_dim(input logic [9:0] d, input string req);
    exp_t e;
    model_dim = d;
    e.is_disp = 1'b0; e.disp = model_disp; e.dim = model_dim; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic send_disp(input logic [110:0] d, input string req);
    push_disp(d, req);
    open_cs();
    shift_bits({17'd0, 1'b1, d}, 112);
    close_cs();
  endtask

  task automatic send_dim(input logic [9:0] d, input logic [4:0] junk, input string req);
    push_dim(d, req);
    open_cs();
    shift_bits({112'd0, 1'b0, junk, d}, 16);
    close_cs();
  endtask

  // monitor: pops one expected item per update pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (display_update && dim_update)
        check(1'b0, "R8 both pulses", 128'd3, 128'd1);
      if (prev_pulse && (display_update || dim_update))
        check(1'b0, "R8 pulse longer than one cycle", 128'd2, 128'd1);
      if (display_update || dim_update) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R7 unexpected update", {126'd0, display_update, dim_update}, 128'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(display_update == e.is_disp, {e.req, " kind"},
                128'(display_update), 128'(e.is_disp));
          check(seg_pattern == e.disp, {e.req, " seg_pattern"},
                128'(seg_pattern), 128'(e.disp));
          check(dim_level == e.dim, {e.req, " dim_level"},
                128'(dim_level), 128'(e.dim));
        end
      end
      prev_pulse = display_update || dim_update;
    end else begin
      prev_pulse = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 128'd0, 128'd1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [110:0] pat_a, pat_b, pat_c, pat_d;
    pat_a = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 15'h5A5A};
    pat_b = {32'hF0F0_1234, 32'hCAFE_0001, 32'h8000_0001, 15'h7FFF};
    pat_c = {32'h1357_9BDF, 32'h2468_ACE0, 32'hFFFF_0000, 15'h0001};
    pat_d = {32'h0F1E_2D3C, 32'h4B5A_6978, 32'h8796_A5B4, 15'h4321};
    model_disp = '0; model_dim = '0; prev_pulse = 1'b0;
    ser_cs_n = 1'b1; ser_clk = 1'b0; ser_data = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1ns rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(seg_pattern == '0, "R1 seg_pattern", 128'(seg_pattern), 128'd0);
    check(dim_level == '0, "R1 dim_level", 128'(dim_level), 128'd0);
    check(!display_update && !dim_update, "R1 pulses",
          {126'd0, display_update, dim_update}, 128'd0);

    // R2/R4/R5: display frames
    send_disp(pat_a, "R5 display frame A");
    // R6: dimming frames, junk positions ignored
    send_dim(10'h3F8, 5'b10101, "R6 dim 3F8");
    send_dim(10'h1FF, 5'b11111, "R6 dim 1FF");
    send_disp(pat_b, "R2 display frame B");

    // R7: short frame dropped
    open_cs();
    shift_bits(128'hFFFF_FFFF, 10);
    close_cs();
    @(negedge clk);
    check(seg_pattern == pat_b, "R7 seg kept", 128'(seg_pattern), 128'(pat_b));
    check(dim_level == 10'h1FF, "R7 dim kept", 128'(dim_level), 128'h1FF);

    // R3: split frame around clocks with chip select high
    begin
      logic [127:0] fr;
      fr = {17'd0, 1'b1, pat_c};
      open_cs();
      shift_bits(fr, 10);
      close_cs();
      ser_data = 1'b1;
      shift_bits(128'hFF, 5);
      push_disp(pat_c, "R3 split frame");
      open_cs();
      shift_bits(fr >> 10, 102);
      close_cs();
    end

    // R9: over-long frame keeps only the last 112 bits
    push_disp(pat_d, "R9 long frame");
    open_cs();
    shift_bits({9'd0, 1'b1, pat_d, 8'hA5}, 120);
    close_cs();

    send_dim(10'h000, 5'b01010, "R6 dim zero");
    send_dim(10'h3FF, 5'b00000, "R6 dim max");

    repeat (20) @(negedge clk);
    check(sb_q.size() == 0, "R4 all updates seen", 128'(sb_q.size()), 128'd0);
    check(seg_pattern == pat_d, "R6 seg untouched by dim", 128'(seg_pattern), 128'(pat_d));
    check(dim_level == 10'h3FF, "R6 final dim", 128'(dim_level), 128'h3FF);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule